// File: doc/BRIEF.md
# Four-Bit Ones-Complement Adder/Subtractor with Segment Readout

This block adds or subtracts two 4-bit operands using ones-complement arithmetic. A single mode bit picks the operation. For subtraction, each bit of the second operand is XOR-ed with the mode bit, which inverts it. The two operands are then summed. The carry out of that first sum is fed back into the least significant bit by a second addition. This is the end-around carry. The fed-back carry is applied in both modes, just as a wired carry-out-to-carry-in loop would behave.

The corrected 4-bit value goes to a BCD glyph decoder that drives a common-anode seven-segment digit, so a segment is lit when its line is low. Codes above nine blank the digit. A sign flag marks a subtraction that produced no end-around carry. In that case the difference is negative and the value shown is its ones-complement form.

All outputs are registered once on the rising clock edge, with a synchronous active-high reset.

Top module: `oc_addsub_disp`

## Requirements
- R1: While reset is high, each clock edge sets result to 0, the carry flag to 0, the sign flag to 0 and all seven segment lines high (dark).
- R2: With mode 0 (add), one edge after the inputs are applied, result equals ((A+B) mod 16 + carry of A+B) mod 16.
- R3: With mode 1 (subtract), B is bitwise inverted before the sum, and one edge later result equals ((A+~B) mod 16 + carry of A+~B) mod 16.
- R4: The carry flag equals the carry out of the first 4-bit sum (bit 4 of A+B or A+~B). Any carry from the second addition is dropped.
- R5: The sign flag is 1 only when mode is 1 and the first sum produced no carry. It is 0 in add mode.
- R6: For result codes 0 to 9, seg_n[6:0] = {g,f,e,d,c,b,a} is the inverse of these active-high patterns: 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07, 8=7F, 9=6F (hex).
- R7: For result codes 10 to 15, all seven segment lines are high.
- R8: Subtracting equal operands gives result 15 (negative zero), carry 0, sign 1 and a blank digit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 4 | First operand (minuend) |
| op_b | input | 4 | Second operand (subtrahend in mode 1) |
| mode | input | 1 | 0 = add, 1 = subtract |
| result | output | 4 | Registered corrected sum |
| eac_out | output | 1 | Registered carry of the first sum |
| neg_out | output | 1 | Registered sign: subtraction without end-around carry |
| seg_n | output | 7 | Registered active-low segments {g,f,e,d,c,b,a} |

## Verification
The sweep covers every operand pair in both modes. It therefore hits the pairs where the raw carry is set and the pairs where it is not. A design that skipped the carry feedback would return results one too low there. A design that inverted B in add mode, or never inverted it, would fail half the sweep. Equal operands under subtraction must give negative zero (all ones), a set sign flag and a dark digit. A sign rule keyed on the wrong carry polarity, or left active in add mode, shows up at once. Results of ten and above check the blanking. Each digit from zero to nine checks the segment wiring order, so swapped segments or active-high drive are caught.

// File: rtl/oc_pkg.sv
package oc_pkg;

    localparam int unsigned DATA_W  = 4;
    localparam int unsigned SEG_W   = 7;
    localparam int unsigned BCD_MAX = 9;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [SEG_W-1:0]  seg_t;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_e;

    // First-pass sum: carry on top of the data word
    typedef struct packed {
        logic  carry;
        word_t sum;
    } raw_sum_t;

    // Datapath result after end-around correction
    typedef struct packed {
        word_t value;
        logic  eac;
        logic  neg;
    } alu_res_t;

    localparam seg_t SEG_DARK = '1;

    // Active-high glyph, bit order {g,f,e,d,c,b,a}
    function automatic seg_t glyph_lit(input word_t code);
        seg_t g;
        case (code)
            word_t'(0): g = 7'h3F;
            word_t'(1): g = 7'h06;
            word_t'(2): g = 7'h5B;
            word_t'(3): g = 7'h4F;
            word_t'(4): g = 7'h66;
            word_t'(5): g = 7'h6D;
            word_t'(6): g = 7'h7D;
            word_t'(7): g = 7'h07;
            word_t'(8): g = 7'h7F;
            word_t'(9): g = 7'h6F;
            default:    g = '0;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/oc_operand_cond.sv
module oc_operand_cond
    import oc_pkg::*;
(
    input  word_t b_in,
    input  op_e   op,
    output word_t b_out
);
    logic inv_bit;
    assign inv_bit = (op == OP_SUB);

    // Per-bit XOR with the mode bit: pass-through for add, invert for subtract
    for (genvar i = 0; i < int'(DATA_W); i++) begin : g_xor
        assign b_out[i] = b_in[i] ^ inv_bit;
    end
endmodule

// File: rtl/oc_eac_adder.sv
module oc_eac_adder
    import oc_pkg::*;
(
    input  word_t    a,
    input  word_t    b_cond,
    input  op_e      op,
    output alu_res_t res
);
    raw_sum_t raw;

    always_comb begin
        raw       = raw_sum_t'({1'b0, a} + {1'b0, b_cond});
        // Second pass folds the carry into bit 0; its own carry is dropped
        res.value = raw.sum + word_t'(raw.carry);
        res.eac   = raw.carry;
        res.neg   = (op == OP_SUB) && !raw.carry;
    end
endmodule

// File: rtl/oc_seg_decoder.sv
module oc_seg_decoder
    import oc_pkg::*;
(
    input  word_t code,
    output seg_t  seg_n
);
    always_comb begin
        if (code > word_t'(BCD_MAX)) seg_n = SEG_DARK;
        else                         seg_n = ~glyph_lit(code);
    end
endmodule

// File: rtl/oc_addsub_disp.sv
module oc_addsub_disp
    import oc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] op_a,
    input  logic [3:0] op_b,
    input  logic       mode,
    output logic [3:0] result,
    output logic       eac_out,
    output logic       neg_out,
    output logic [6:0] seg_n
);
    op_e      op_sel;
    word_t    b_cond;
    alu_res_t alu_d;
    alu_res_t alu_q;
    seg_t     seg_d;
    seg_t     seg_q;

    assign op_sel = op_e'(mode);

    oc_operand_cond u_cond (
        .b_in  (op_b),
        .op    (op_sel),
        .b_out (b_cond)
    );

    oc_eac_adder u_add (
        .a      (op_a),
        .b_cond (b_cond),
        .op     (op_sel),
        .res    (alu_d)
    );

    oc_seg_decoder u_dec (
        .code  (alu_d.value),
        .seg_n (seg_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            alu_q <= '0;
            seg_q <= SEG_DARK;
        end else begin
            alu_q <= alu_d;
            seg_q <= seg_d;
        end
    end

    assign result  = alu_q.value;
    assign eac_out = alu_q.eac;
    assign neg_out = alu_q.neg;
    assign seg_n   = seg_q;
endmodule

// File: rtl/oc_addsub_disp_chk.sv
module oc_addsub_disp_chk (
    input logic       clk,
    input logic       rst,
    input logic [3:0] op_a,
    input logic [3:0] op_b,
    input logic       mode,
    input logic [3:0] result,
    input logic       eac_out,
    input logic       neg_out,
    input logic [6:0] seg_n
);
    logic       primed;
    logic [4:0] add5;
    logic [4:0] sub5;
    logic [3:0] add_fix;
    logic [3:0] sub_fix;

    always_ff @(posedge clk) begin
        if (rst) primed <= 1'b0;
        else     primed <= 1'b1;
    end

    always_comb begin
        add5    = {1'b0, op_a} + {1'b0, op_b};
        sub5    = {1'b0, op_a} + {1'b0, ~op_b};
        add_fix = add5[3:0] + {3'b000, add5[4]};
        sub_fix = sub5[3:0] + {3'b000, sub5[4]};
    end

    assert_add_value_R2: assert property (@(posedge clk) disable iff (rst || !primed)
        !$past(mode) |-> result == $past(add_fix));

    assert_sub_value_R3: assert property (@(posedge clk) disable iff (rst || !primed)
        $past(mode) |-> result == $past(sub_fix));

    assert_carry_flag_R4: assert property (@(posedge clk) disable iff (rst || !primed)
        eac_out == ($past(mode) ? $past(sub5[4]) : $past(add5[4])));

    assert_sign_add_clear_R5: assert property (@(posedge clk) disable iff (rst || !primed)
        !$past(mode) |-> !neg_out);

    assert_sign_sub_R5: assert property (@(posedge clk) disable iff (rst || !primed)
        $past(mode) |-> neg_out == !eac_out);

    assert_digit_lit_R6: assert property (@(posedge clk) disable iff (rst || !primed)
        result <= 4'd9 |-> seg_n != 7'h7F);

    assert_blank_high_R7: assert property (@(posedge clk) disable iff (rst || !primed)
        result > 4'd9 |-> seg_n == 7'h7F);

    assert_neg_zero_R8: assert property (@(posedge clk) disable iff (rst || !primed)
        ($past(mode) && $past(op_a) == $past(op_b)) |-> (result == 4'hF && neg_out));
endmodule

bind oc_addsub_disp oc_addsub_disp_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .op_a    (op_a),
    .op_b    (op_b),
    .mode    (mode),
    .result  (result),
    .eac_out (eac_out),
    .neg_out (neg_out),
    .seg_n   (seg_n)
);

// File: tb/test_oc_addsub_disp.sv
`timescale 1ns/1ps
module test_oc_addsub_disp;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] op_a = '0;
    logic [3:0] op_b = '0;
    logic       mode = 1'b0;
    logic [3:0] result;
    logic       eac_out;
    logic       neg_out;
    logic [6:0] seg_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    oc_addsub_disp i_oc_addsub_disp (
        .clk     (clk),
        .rst     (rst),
        .op_a    (op_a),
        .op_b    (op_b),
        .mode    (mode),
        .result  (result),
        .eac_out (eac_out),
        .neg_out (neg_out),
        .seg_n   (seg_n)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (a=%0d b=%0d mode=%0d)",
                     req, act, exp, op_a, op_b, mode);
        end
    endtask

    function automatic int exp_segs(input int code);
        int lit;
        case (code)
            0: lit = 'h3F;  1: lit = 'h06;  2: lit = 'h5B;  3: lit = 'h4F;
            4: lit = 'h66;  5: lit = 'h6D;  6: lit = 'h7D;  7: lit = 'h07;
            8: lit = 'h7F;  9: lit = 'h6F;
            default: lit = 0;
        endcase
        return (~lit) & 'h7F;
    endfunction

    task automatic apply(input int a, input int b, input int m);
        int bb, s5, carry, res;
        string tag_v, tag_s;
        @(negedge clk);
        op_a = 4'(a); op_b = 4'(b); mode = m[0];
        @(negedge clk);
        bb    = m ? ((~b) & 'hF) : b;
        s5    = a + bb;
        carry = (s5 >> 4) & 1;
        res   = ((s5 & 'hF) + carry) & 'hF;
        tag_v = m ? "R3 value" : "R2 value";
        check(tag_v, result, res);
        check("R4 carry", eac_out, carry);
        check("R5 sign", neg_out, (m == 1 && carry == 0) ? 1 : 0);
        tag_s = (res > 9) ? "R7 blank" : "R6 segments";
        check(tag_s, seg_n, exp_segs(res));
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        op_a = 4'd7; op_b = 4'd5; mode = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 result", result, 0);
        check("R1 carry", eac_out, 0);
        check("R1 sign", neg_out, 0);
        check("R1 segments", seg_n, 'h7F);
        rst = 1'b0;

        // Directed corners
        apply(7, 1, 1);                 // R3: 7-1 = 6 via end-around carry
        check("R3 directed 7-1", result, 6);
        apply(9, 9, 1);                 // R8: negative zero
        check("R8 result", result, 15);
        check("R8 sign", neg_out, 1);
        check("R8 blank", seg_n, 'h7F);
        apply(15, 15, 0);               // R2/R4: 30 -> 14 + 1 = 15
        check("R2 max add", result, 15);
        check("R4 max add carry", eac_out, 1);

        // Full sweep
        for (int m = 0; m < 2; m++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++)
                    apply(a, b, m);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule